// File: doc/BRIEF.md
# Amplifier Fault and Mute Supervisor

This block supervises the control side of a two-channel switching power stage. Each clock it takes a die-temperature sample and three asynchronous control lines: an active-low power-down input, an active-low mute input and a trip flag that is raised whenever any output transistor carries too much current. It drives three active-low error flags (thermal warning, thermal shutdown, overcurrent) and three requests to the power stage: shut down, mute, and start the pop-suppression ramp.

Thermal faults use a hysteresis band. The warning and shutdown flags each have their own set threshold and share one clear threshold, and they clear on their own. An overcurrent trip is held until the part is powered down or the mute input is taken low and then high again. A power-down request must stay low for a minimum number of clocks before it is obeyed, so short glitches are ignored. The part cannot leave mute while it is powered down. When both a thermal shutdown and an overcurrent trip are present, shutdown decides the output state.

Top module: `amp_guard`

## Requirements
- R1: When the temperature sample exceeds WARN_ON (default 135), therm_warn_n is low one clock later.
- R2: When the temperature sample exceeds SHUT_ON (default 150), therm_shut_n is low one clock later and shut_req is high one clock after that.
- R3: Both thermal flags return high only one clock after a sample below CLR_BELOW (default 120). For samples from CLR_BELOW up to their own set threshold, the flags keep their state.
- R4: An overcurrent trip drives oc_err_n low three clocks after oc_trip rises and drives mute_req high one clock later, while the part is not powered down and not in shutdown.
- R5: oc_err_n stays low after oc_trip falls. It returns high only through power-down, or when mute_n is taken low and then high while the trip is held. In the second case it returns high three clocks after mute_n rises.
- R6: An accepted power-down makes shut_req high and clears the overcurrent trip. While powered down, mute_n and oc_trip have no effect. shut_req falls four clocks after rstpd_n rises.
- R7: pop_go is a one-clock pulse. It fires on the clock where shut_req falls and on the clock where mute_req falls while shut_req stays low.
- R8: A low pulse on rstpd_n that lasts fewer than RST_MIN_CYC clocks (default 25, which is 500 ns at 50 MHz) is ignored. A low pulse of RST_MIN_CYC clocks or more powers the part down.
- R9: While shut_req is high, mute_req is low, even when an overcurrent trip is held.
- R10: A synchronous reset (rst high) gives all error flags high, shut_req high, mute_req low and pop_go low.
- R11: When not shut down, mute_n low drives mute_req high three clocks later. mute_n high with no trip held drives it low three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_c | input | TEMP_W | Die temperature in degrees C, unsigned, sampled each clock |
| rstpd_n | input | 1 | Asynchronous active-low power-down request |
| mute_n | input | 1 | Asynchronous active-low mute request |
| oc_trip | input | 1 | Asynchronous overcurrent flag from the current sensors |
| therm_shut_n | output | 1 | Active-low thermal shutdown flag |
| therm_warn_n | output | 1 | Active-low thermal warning flag |
| oc_err_n | output | 1 | Active-low latched overcurrent flag |
| mute_req | output | 1 | Mute request to the power stage |
| shut_req | output | 1 | Shutdown request to the power stage |
| pop_go | output | 1 | One-clock start pulse for the pop-suppression ramp |

## Verification
Each result has a fixed latency. Thermal flags follow the temperature sample by one clock, and shut_req follows the thermal flag by one more. A change on an asynchronous input takes two synchroniser clocks and then one register stage, so mute_req follows mute_n by three clocks, oc_err_n follows oc_trip by three, and shut_req follows a released power-down by four. The bench drives every input just after a falling edge, then waits exactly that many rising edges and samples at the next falling edge. It checks the clock before the change where it matters, so that a change one clock early or late is also caught. The temperature is swept through every code, first upward and then downward, against an arithmetic hysteresis model. Power-down pulse widths are swept from one clock to past the minimum, watching shut_req.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  // asynchronous control lines, grouped for a single synchroniser bank
  typedef struct packed {
    logic rstpd_n;
    logic mute_n;
    logic oc;
  } async_in_t;

  localparam int ASYNC_W = $bits(async_in_t);

endpackage

// File: rtl/ag_sync2.sv
module ag_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stg1[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        stg1[i] <= d[i];
        q[i]    <= stg1[i];
      end
    end
  end

endmodule

// File: rtl/ag_thermal.sv
module ag_thermal #(
  parameter int TW        = 8,
  parameter int WARN_ON   = 135,
  parameter int SHUT_ON   = 150,
  parameter int CLR_BELOW = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] temp,
  output logic          warn_n,
  output logic          shut_n
);

  localparam logic [TW-1:0] WARN_T = TW'(WARN_ON);
  localparam logic [TW-1:0] SHUT_T = TW'(SHUT_ON);
  localparam logic [TW-1:0] CLR_T  = TW'(CLR_BELOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_n <= 1'b1;
      shut_n <= 1'b1;
    end else if (temp < CLR_T) begin
      warn_n <= 1'b1;
      shut_n <= 1'b1;
    end else begin
      if (temp > WARN_T) warn_n <= 1'b0;
      if (temp > SHUT_T) shut_n <= 1'b0;
    end
  end

  // R1
  a_r1_warn_set: assert property (@(posedge clk) disable iff (rst)
    (temp > WARN_T) |=> !warn_n);
  // R2
  a_r2_shut_set: assert property (@(posedge clk) disable iff (rst)
    (temp > SHUT_T) |=> !shut_n);
  a_r2_shut_has_warn: assert property (@(posedge clk) disable iff (rst)
    !shut_n |-> !warn_n);
  // R3
  a_r3_warn_hold: assert property (@(posedge clk) disable iff (rst)
    (temp >= CLR_T && temp <= WARN_T) |=> $stable(warn_n));
  a_r3_shut_hold: assert property (@(posedge clk) disable iff (rst)
    (temp >= CLR_T && temp <= SHUT_T) |=> $stable(shut_n));

endmodule

// File: rtl/ag_rst_filter.sv
module ag_rst_filter #(
  parameter int MIN_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic rstpd_n_s,
  output logic pd
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_CYC);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= FULL;
      pd      <= 1'b1;
    end else if (!rstpd_n_s) begin
      if (low_cnt != FULL) low_cnt <= low_cnt + CW'(1);
      if (low_cnt == LAST) pd <= 1'b1;
    end else begin
      low_cnt <= '0;
      pd      <= 1'b0;
    end
  end

  // R8
  a_r8_no_early_pd: assert property (@(posedge clk) disable iff (rst)
    (!pd && low_cnt < LAST) |=> !pd);
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    rstpd_n_s |=> !pd);

endmodule

// File: rtl/ag_fault_seq.sv
module ag_fault_seq (
  input  logic clk,
  input  logic rst,
  input  logic pd,
  input  logic mute_n_s,
  input  logic oc_s,
  input  logic therm_shut_n,
  output logic oc_err_n,
  output logic mute_req,
  output logic shut_req,
  output logic pop_go
);

  logic clr_arm;
  logic nxt_shut;
  logic nxt_mute;

  // overcurrent latch; a mute low-then-high while held clears it
  always_ff @(posedge clk) begin
    if (rst) begin
      oc_err_n <= 1'b1;
      clr_arm  <= 1'b0;
    end else if (pd) begin
      oc_err_n <= 1'b1;
      clr_arm  <= 1'b0;
    end else if (oc_s) begin
      oc_err_n <= 1'b0;
      clr_arm  <= 1'b0;
    end else if (!oc_err_n) begin
      if (!mute_n_s) begin
        clr_arm <= 1'b1;
      end else if (clr_arm) begin
        oc_err_n <= 1'b1;
        clr_arm  <= 1'b0;
      end
    end
  end

  // output-state sequencing: shutdown outranks mute
  always_comb begin
    nxt_shut = pd | ~therm_shut_n;
    nxt_mute = ~nxt_shut & (~mute_n_s | ~oc_err_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shut_req <= 1'b1;
      mute_req <= 1'b0;
      pop_go   <= 1'b0;
    end else begin
      shut_req <= nxt_shut;
      mute_req <= nxt_mute;
      pop_go   <= (shut_req & ~nxt_shut) | (mute_req & ~nxt_shut & ~nxt_mute);
    end
  end

  // R5
  a_r5_oc_hold: assert property (@(posedge clk) disable iff (rst)
    (!oc_err_n && !pd && mute_n_s && !clr_arm) |=> !oc_err_n);
  // R6
  a_r6_pd_shut: assert property (@(posedge clk) disable iff (rst)
    pd |=> shut_req);
  a_r6_pd_clears_oc: assert property (@(posedge clk) disable iff (rst)
    pd |=> oc_err_n);
  // R7
  a_r7_pop_single: assert property (@(posedge clk) disable iff (rst)
    pop_go |=> !pop_go);
  // R9
  a_r9_shut_over_mute: assert property (@(posedge clk) disable iff (rst)
    shut_req |-> !mute_req);

endmodule

// File: rtl/amp_guard.sv
module amp_guard #(
  parameter int TEMP_W      = 8,
  parameter int WARN_ON     = 135,
  parameter int SHUT_ON     = 150,
  parameter int CLR_BELOW   = 120,
  parameter int RST_MIN_CYC = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic              rstpd_n,
  input  logic              mute_n,
  input  logic              oc_trip,
  output logic              therm_shut_n,
  output logic              therm_warn_n,
  output logic              oc_err_n,
  output logic              mute_req,
  output logic              shut_req,
  output logic              pop_go
);

  import amp_guard_pkg::*;

  async_in_t raw_in;
  async_in_t syn_in;
  logic      pd;

  assign raw_in = '{rstpd_n: rstpd_n, mute_n: mute_n, oc: oc_trip};

  ag_sync2 #(.W(ASYNC_W)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  ag_thermal #(
    .TW       (TEMP_W),
    .WARN_ON  (WARN_ON),
    .SHUT_ON  (SHUT_ON),
    .CLR_BELOW(CLR_BELOW)
  ) i_thermal (
    .clk    (clk),
    .rst    (rst),
    .temp   (temp_c),
    .warn_n (therm_warn_n),
    .shut_n (therm_shut_n)
  );

  ag_rst_filter #(.MIN_CYC(RST_MIN_CYC)) i_rst_filter (
    .clk       (clk),
    .rst       (rst),
    .rstpd_n_s (syn_in.rstpd_n),
    .pd        (pd)
  );

  ag_fault_seq i_seq (
    .clk          (clk),
    .rst          (rst),
    .pd           (pd),
    .mute_n_s     (syn_in.mute_n),
    .oc_s         (syn_in.oc),
    .therm_shut_n (therm_shut_n),
    .oc_err_n     (oc_err_n),
    .mute_req     (mute_req),
    .shut_req     (shut_req),
    .pop_go       (pop_go)
  );

endmodule

// File: tb/test_amp_guard.sv
module test_amp_guard;

  localparam int WARN_ON   = 135;
  localparam int SHUT_ON   = 150;
  localparam int CLR_BELOW = 120;
  localparam int MIN_CYC   = 25;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] temp_c;
  logic       rstpd_n, mute_n, oc_trip;
  logic       therm_shut_n, therm_warn_n, oc_err_n, mute_req, shut_req, pop_go;

  int n_chk  = 0;
  int n_fail = 0;
  bit m_warn = 1'b0;
  bit m_shut = 1'b0;

  always #10 clk = ~clk;

  amp_guard #(
    .TEMP_W(8), .WARN_ON(WARN_ON), .SHUT_ON(SHUT_ON),
    .CLR_BELOW(CLR_BELOW), .RST_MIN_CYC(MIN_CYC)
  ) i_amp_guard (
    .clk(clk), .rst(rst), .temp_c(temp_c), .rstpd_n(rstpd_n),
    .mute_n(mute_n), .oc_trip(oc_trip), .therm_shut_n(therm_shut_n),
    .therm_warn_n(therm_warn_n), .oc_err_n(oc_err_n), .mute_req(mute_req),
    .shut_req(shut_req), .pop_go(pop_go)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic temp_step(input int t);
    temp_c = 8'(t);
    tick(1);
    if (t > SHUT_ON) m_shut = 1'b1;
    if (t > WARN_ON) m_warn = 1'b1;
    if (t < CLR_BELOW) begin
      m_warn = 1'b0;
      m_shut = 1'b0;
    end
    chk($sformatf("R1/R3 warn at temp %0d", t), int'(therm_warn_n), int'(!m_warn));
    chk($sformatf("R2/R3 shut at temp %0d", t), int'(therm_shut_n), int'(!m_shut));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; temp_c = 8'd25; rstpd_n = 1'b0; mute_n = 1'b0; oc_trip = 1'b0;
    tick(4);
    // R10 reset state
    chk("R10 warn_n", int'(therm_warn_n), 1);
    chk("R10 shut_n", int'(therm_shut_n), 1);
    chk("R10 oc_err_n", int'(oc_err_n), 1);
    chk("R10 shut_req", int'(shut_req), 1);
    chk("R10 mute_req", int'(mute_req), 0);
    chk("R10 pop_go", int'(pop_go), 0);
    rst = 1'b0;
    tick(2);

    // R6 release from power-down, mute still held
    rstpd_n = 1'b1;
    tick(3);
    chk("R6 shut_req before release", int'(shut_req), 1);
    tick(1);
    chk("R6 shut_req released", int'(shut_req), 0);
    chk("R11 mute_req after release", int'(mute_req), 1);
    chk("R7 pop on leaving reset", int'(pop_go), 1);
    tick(1);
    chk("R7 pop one clock", int'(pop_go), 0);

    // R11 unmute and re-mute
    mute_n = 1'b1;
    tick(2);
    chk("R11 mute_req not yet", int'(mute_req), 1);
    tick(1);
    chk("R11 mute_req released", int'(mute_req), 0);
    chk("R7 pop on unmute", int'(pop_go), 1);
    tick(1);
    chk("R7 pop cleared", int'(pop_go), 0);
    mute_n = 1'b0;
    tick(2);
    chk("R11 mute_req before due", int'(mute_req), 0);
    tick(1);
    chk("R11 mute_req set", int'(mute_req), 1);
    mute_n = 1'b1;
    tick(3);
    chk("R11 mute_req cleared", int'(mute_req), 0);
    tick(2);

    // R1 R2 R3 full temperature sweep up then down
    for (int t = 0; t < 256; t++) temp_step(t);
    for (int t = 255; t >= 0; t--) temp_step(t);
    temp_c = 8'd25;
    tick(4);

    // R2 shut_req timing, R3 band hold
    temp_c = 8'd151;
    tick(1);
    chk("R2 shut_n set", int'(therm_shut_n), 0);
    chk("R2 shut_req not yet", int'(shut_req), 0);
    tick(1);
    chk("R2 shut_req set", int'(shut_req), 1);
    temp_c = 8'd121;
    tick(3);
    chk("R3 shut held at 121", int'(therm_shut_n), 0);
    chk("R3 warn held at 121", int'(therm_warn_n), 0);
    temp_c = 8'd119;
    tick(1);
    chk("R3 shut cleared", int'(therm_shut_n), 1);
    chk("R3 warn cleared", int'(therm_warn_n), 1);
    tick(1);
    chk("R2 shut_req cleared", int'(shut_req), 0);
    chk("R7 pop on leaving shutdown", int'(pop_go), 1);
    tick(2);

    // R4 R5 overcurrent latch and mute-toggle clear
    oc_trip = 1'b1;
    tick(2);
    chk("R4 oc_err_n before due", int'(oc_err_n), 1);
    tick(1);
    chk("R4 oc_err_n set", int'(oc_err_n), 0);
    tick(1);
    chk("R4 mute_req forced", int'(mute_req), 1);
    oc_trip = 1'b0;
    tick(6);
    chk("R5 oc latched", int'(oc_err_n), 0);
    chk("R5 mute held", int'(mute_req), 1);
    mute_n = 1'b0;
    tick(4);
    chk("R5 oc held during mute", int'(oc_err_n), 0);
    mute_n = 1'b1;
    tick(2);
    chk("R5 oc before clear", int'(oc_err_n), 0);
    tick(1);
    chk("R5 oc cleared by toggle", int'(oc_err_n), 1);
    tick(1);
    chk("R5 mute_req released", int'(mute_req), 0);
    chk("R7 pop after oc clear", int'(pop_go), 1);
    tick(2);

    // R9 shutdown outranks overcurrent mute
    oc_trip = 1'b1;
    temp_c = 8'd200;
    tick(5);
    chk("R9 shut_req", int'(shut_req), 1);
    chk("R9 mute_req low", int'(mute_req), 0);
    chk("R9 oc_err_n", int'(oc_err_n), 0);
    oc_trip = 1'b0;
    temp_c = 8'd25;
    tick(2);
    chk("R9 shut_req dropped", int'(shut_req), 0);
    chk("R9 mute from held trip", int'(mute_req), 1);

    // R6 power-down clears trip, ignores mute and trip
    rstpd_n = 1'b0;
    tick(MIN_CYC + 2);
    chk("R6 oc before pd clear", int'(oc_err_n), 0);
    tick(1);
    chk("R6 shut_req in pd", int'(shut_req), 1);
    chk("R6 oc cleared", int'(oc_err_n), 1);
    chk("R6 mute_req low in pd", int'(mute_req), 0);
    mute_n = 1'b0;
    oc_trip = 1'b1;
    tick(5);
    chk("R6 mute ignored", int'(mute_req), 0);
    chk("R6 trip ignored", int'(oc_err_n), 1);
    oc_trip = 1'b0;
    mute_n = 1'b1;
    tick(4);
    rstpd_n = 1'b1;
    tick(4);
    chk("R6 run after pd", int'(shut_req), 0);
    chk("R6 unmuted after pd", int'(mute_req), 0);
    chk("R7 pop straight to run", int'(pop_go), 1);
    tick(3);

    // R8 pulse width sweep
    for (int w = 1; w <= MIN_CYC + 2; w++) begin
      bit seen = 1'b0;
      rstpd_n = 1'b0;
      for (int k = 0; k < w; k++) begin
        tick(1);
        if (shut_req) seen = 1'b1;
      end
      rstpd_n = 1'b1;
      for (int k = 0; k < 8; k++) begin
        tick(1);
        if (shut_req) seen = 1'b1;
      end
      chk($sformatf("R8 pulse %0d clocks", w), int'(seen), int'(w >= MIN_CYC));
      chk($sformatf("R8 settled after %0d", w), int'(shut_req), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule